// File: doc/BRIEF.md
# Interface Adapter Timer and Interrupt Core

This block is a byte-wide register file of sixteen entries that sits behind a simple host bus. The host selects one entry with four address bits, reads it through a combinational data path and writes it on a clock edge. Several entries have side effects. Some reads or writes clear interrupt flags. One write loads a counter. The interrupt-enable entry uses a set/clear encoding. The block holds two general data bytes with their direction bytes, a serial data byte, two control bytes and an alias data byte. None of these drives pins.

Two 16-bit down-counters step once for each cycle in which the `tick` input is high. The integration drives `tick` at roughly 783 kHz. The first counter can run free and reload from its latch, or it can run one-shot. The second counter is always one-shot. Counter events and an external serial-done pulse set flag bits. Two of these flags can drive a single level interrupt output.

Top module: `ifaTimerCore`

## Requirements
- R1: The register is selected by bus address bits 12:9. Indices are: 0 data B, 1 data A, 2 direction B, 3 direction A, 4 counter-1 low, 5 counter-1 high, 6 latch-1 low, 7 latch-1 high, 8 counter-2 low, 9 counter-2 high, 10 shift data, 11 aux control, 12 peripheral control, 13 flags, 14 enables, 15 data A alias. Indices 0-3, 10, 11, 12 and 15 read back the last byte written.
- R2: A write to index 14 with bit 7 = 1 ORs bits 6:0 into the enable mask. With bit 7 = 0, every bit written as 1 is removed from the mask.
- R3: A read of index 14 returns {1, mask}. A read of index 13 returns the seven flags in bits 6:0, with bit 7 = 1 when any flag is both set and enabled.
- R4: Writing 1s to index 13 clears the matching flags, and 0s leave flags unchanged. `irq` is high exactly when flag bit 2 (serial) or flag bit 6 (counter 1) is set and enabled. Flag bit 5 never drives `irq`.
- R5: A write to index 5 sets latch-1 high, clears flag 6 and loads counter 1 with the full new latch.
- R6: A write to index 4 or index 6 changes only latch-1 low. A write to index 7 sets latch-1 high and clears flag 6. Neither write touches counter 1.
- R7: A read of index 4 clears flag 6. A read of index 5 leaves it set.
- R8: A write to index 8 stores a low byte only. A write to index 9 loads counter 2 with {written byte, stored low byte}. Counter 2 sets flag 5 once when it reaches 0 after a load. Reading index 8 clears flag 5.
- R9: With aux bits 7:6 = 01, counter 1 runs latch, ..., 0, 0xFFFF, then latch again, so the period is latch+2 ticks. Flag 6 is set on every arrival at 0.
- R10: With other aux bits 7:6 values, counter 1 wraps through 0xFFFF and keeps counting. It sets flag 6 only on the first arrival at 0 after a load.
- R11: After reset: latch 1 and counter 1 = 0xFFFF, counter 2 = 0xFFFF, stored counter-2 low byte = 0, enables = 0, flags = 0, `irq` = 0.
- R12: A `shiftEvent` pulse sets flag 2. Reading index 10 clears flag 2.
- R13: Counters change only in cycles with `tick` high, or on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Access select |
| wrEn | input | 1 | Write strobe, qualified by sel |
| rdEn | input | 1 | Read strobe for side effects, qualified by sel |
| busAddr | input | 4 (bits 12:9) | Register index field of the bus address |
| wrData | input | 8 | Write data |
| tick | input | 1 | Counter step enable |
| shiftEvent | input | 1 | Serial byte done pulse, sets flag 2 |
| rdData | output | 8 | Read data for the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
The bench times the free-running counter-1 period across the 0xFFFF step. A design that reloads on reaching 0 gives a period of latch+1 and sets the flag one tick early. It also runs a one-shot counter through a full 65536-tick wrap. A design that re-arms without a fresh load raises a second flag. It also checks which accesses clear flags and which do not: a counter-1 high read, a latch-high write and write-0 bits of the flag register. Swapped clear paths show up as flags that stay set or vanish. It also checks the set/clear encoding of the enable register and the summary bit 7, and that the counter-2 flag stays off `irq`.

// File: rtl/ifaPkg.sv
package ifaPkg;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_DATAB   = 4'd0,
    IDX_DATAA   = 4'd1,
    IDX_DIRB    = 4'd2,
    IDX_DIRA    = 4'd3,
    IDX_C1LO    = 4'd4,
    IDX_C1HI    = 4'd5,
    IDX_L1LO    = 4'd6,
    IDX_L1HI    = 4'd7,
    IDX_C2LO    = 4'd8,
    IDX_C2HI    = 4'd9,
    IDX_SHIFT   = 4'd10,
    IDX_AUX     = 4'd11,
    IDX_PERIPH  = 4'd12,
    IDX_FLAGS   = 4'd13,
    IDX_ENABLES = 4'd14,
    IDX_ALIAS   = 4'd15
  } regIdxE;

  localparam int FLAG_SHIFT = 2;
  localparam int FLAG_C2    = 5;
  localparam int FLAG_C1    = 6;

  typedef struct packed {
    logic wrDataB;
    logic wrDataA;
    logic wrDirB;
    logic wrDirA;
    logic wrL1Lo;
    logic wrC1Hi;
    logic wrL1Hi;
    logic wrC2Lo;
    logic wrC2Hi;
    logic wrShift;
    logic wrAux;
    logic wrPeriph;
    logic wrFlags;
    logic wrEnables;
    logic wrAlias;
    logic rdC1Lo;
    logic rdC2Lo;
    logic rdShift;
  } ifaStrobeT;
endpackage

// File: rtl/ifaCtrl.sv
module ifaCtrl
  import ifaPkg::*;
(
  input  logic             sel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] regSel,
  output regIdxE           rdIdx,
  output ifaStrobeT        strb
);
  regIdxE idx;

  assign idx   = regIdxE'(regSel);
  assign rdIdx = idx;

  always_comb begin
    strb = '0;
    if (sel && wrEn) begin
      case (idx)
        IDX_DATAB:   strb.wrDataB   = 1'b1;
        IDX_DATAA:   strb.wrDataA   = 1'b1;
        IDX_DIRB:    strb.wrDirB    = 1'b1;
        IDX_DIRA:    strb.wrDirA    = 1'b1;
        IDX_C1LO:    strb.wrL1Lo    = 1'b1;
        IDX_C1HI:    strb.wrC1Hi    = 1'b1;
        IDX_L1LO:    strb.wrL1Lo    = 1'b1;
        IDX_L1HI:    strb.wrL1Hi    = 1'b1;
        IDX_C2LO:    strb.wrC2Lo    = 1'b1;
        IDX_C2HI:    strb.wrC2Hi    = 1'b1;
        IDX_SHIFT:   strb.wrShift   = 1'b1;
        IDX_AUX:     strb.wrAux     = 1'b1;
        IDX_PERIPH:  strb.wrPeriph  = 1'b1;
        IDX_FLAGS:   strb.wrFlags   = 1'b1;
        IDX_ENABLES: strb.wrEnables = 1'b1;
        default:     strb.wrAlias   = 1'b1;
      endcase
    end
    if (sel && rdEn) begin
      case (idx)
        IDX_C1LO:  strb.rdC1Lo  = 1'b1;
        IDX_C2LO:  strb.rdC2Lo  = 1'b1;
        IDX_SHIFT: strb.rdShift = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ifaDownCounter.sv
module ifaDownCounter #(
  parameter int W = 16,
  parameter logic [W-1:0] RESET_CNT = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         contMode,
  input  logic [W-1:0] reloadVal,
  output logic [W-1:0] count,
  output logic         zeroHit
);
  logic         armed;
  logic [W-1:0] stepVal;

  always_comb begin
    if (contMode && (count == '1)) stepVal = reloadVal;
    else                           stepVal = count - W'(1);
    zeroHit = tick && !load && (stepVal == '0) && (contMode || armed);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= RESET_CNT;
      armed <= 1'b0;
    end else if (load) begin
      count <= loadVal;
      armed <= 1'b1;
    end else begin
      if (tick) count <= stepVal;
      if (zeroHit) armed <= 1'b0;
    end
  end

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    tick && !load && !(contMode && count == '1) |=> count == $past(count) - W'(1)); // R13
  AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    tick && !load && contMode && count == '1 |=> count == $past(reloadVal)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick && !load |=> $stable(count)); // R13
  AST_HIT_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    zeroHit |=> count == '0); // R10
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    load |=> count == $past(loadVal)); // R5
endmodule

// File: rtl/ifaDatapath.sv
module ifaDatapath
  import ifaPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ifaStrobeT         strb,
  input  regIdxE            rdIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  logic              shiftEvent,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int FLAG_W = DATA_W - 1;
  localparam logic [FLAG_W-1:0] IRQ_MASK =
    FLAG_W'((1 << FLAG_SHIFT) | (1 << FLAG_C1));

  logic [DATA_W-1:0] dataB, dataA, dirB, dirA, shiftQ, auxQ, periphQ, aliasQ;
  logic [FLAG_W-1:0] flagQ, flagNext, enQ;
  logic [CNT_W-1:0]  latch1;
  logic [DATA_W-1:0] low2;
  logic [CNT_W-1:0]  cnt1, cnt2;
  logic              hit1, hit2, freeRun, anyPend;

  assign freeRun = (auxQ[DATA_W-1 -: 2] == 2'b01);
  assign anyPend = |(flagQ & enQ);
  assign irq     = |(flagQ & enQ & IRQ_MASK);

  ifaDownCounter #(.W(CNT_W), .RESET_CNT('1)) cnt1_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .load     (strb.wrC1Hi),
    .loadVal  ({wrData, latch1[DATA_W-1:0]}),
    .contMode (freeRun),
    .reloadVal(latch1),
    .count    (cnt1),
    .zeroHit  (hit1)
  );

  ifaDownCounter #(.W(CNT_W), .RESET_CNT('1)) cnt2_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .load     (strb.wrC2Hi),
    .loadVal  ({wrData, low2}),
    .contMode (1'b0),
    .reloadVal(latch1),
    .count    (cnt2),
    .zeroHit  (hit2)
  );

  always_comb begin
    flagNext = flagQ;
    if (strb.wrFlags) flagNext = flagNext & ~wrData[FLAG_W-1:0];
    if (strb.rdC1Lo || strb.wrC1Hi || strb.wrL1Hi) flagNext[FLAG_C1] = 1'b0;
    if (strb.rdC2Lo)  flagNext[FLAG_C2]    = 1'b0;
    if (strb.rdShift) flagNext[FLAG_SHIFT] = 1'b0;
    if (hit1)         flagNext[FLAG_C1]    = 1'b1;
    if (hit2)         flagNext[FLAG_C2]    = 1'b1;
    if (shiftEvent)   flagNext[FLAG_SHIFT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataB   <= '0;
      dataA   <= '0;
      dirB    <= '0;
      dirA    <= '0;
      shiftQ  <= '0;
      auxQ    <= '0;
      periphQ <= '0;
      aliasQ  <= '0;
      flagQ   <= '0;
      enQ     <= '0;
      latch1  <= '1;
      low2    <= '0;
    end else begin
      flagQ <= flagNext;
      if (strb.wrDataB)  dataB   <= wrData;
      if (strb.wrDataA)  dataA   <= wrData;
      if (strb.wrDirB)   dirB    <= wrData;
      if (strb.wrDirA)   dirA    <= wrData;
      if (strb.wrShift)  shiftQ  <= wrData;
      if (strb.wrAux)    auxQ    <= wrData;
      if (strb.wrPeriph) periphQ <= wrData;
      if (strb.wrAlias)  aliasQ  <= wrData;
      if (strb.wrL1Lo)   latch1[DATA_W-1:0]      <= wrData;
      if (strb.wrL1Hi || strb.wrC1Hi) latch1[CNT_W-1:DATA_W] <= wrData;
      if (strb.wrC2Lo)   low2 <= wrData;
      if (strb.wrEnables) begin
        if (wrData[DATA_W-1]) enQ <= enQ | wrData[FLAG_W-1:0];
        else                  enQ <= enQ & ~wrData[FLAG_W-1:0];
      end
    end
  end

  always_comb begin
    case (rdIdx)
      IDX_DATAB:   rdData = dataB;
      IDX_DATAA:   rdData = dataA;
      IDX_DIRB:    rdData = dirB;
      IDX_DIRA:    rdData = dirA;
      IDX_C1LO:    rdData = cnt1[DATA_W-1:0];
      IDX_C1HI:    rdData = cnt1[CNT_W-1:DATA_W];
      IDX_L1LO:    rdData = latch1[DATA_W-1:0];
      IDX_L1HI:    rdData = latch1[CNT_W-1:DATA_W];
      IDX_C2LO:    rdData = cnt2[DATA_W-1:0];
      IDX_C2HI:    rdData = cnt2[CNT_W-1:DATA_W];
      IDX_SHIFT:   rdData = shiftQ;
      IDX_AUX:     rdData = auxQ;
      IDX_PERIPH:  rdData = periphQ;
      IDX_FLAGS:   rdData = {anyPend, flagQ};
      IDX_ENABLES: rdData = {1'b1, enQ};
      default:     rdData = aliasQ;
    endcase
  end

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFlags && wrData[FLAG_C1] && !hit1 |=> !flagQ[FLAG_C1]); // R4
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnables && wrData[DATA_W-1] |=>
      (enQ & $past(wrData[FLAG_W-1:0])) == $past(wrData[FLAG_W-1:0])); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnables && !wrData[DATA_W-1] |=>
      (enQ & $past(wrData[FLAG_W-1:0])) == '0); // R2
  AST_C1_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdC1Lo && !hit1 |=> !flagQ[FLAG_C1]); // R7
  AST_C2_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdC2Lo && !hit2 |=> !flagQ[FLAG_C2]); // R8
  AST_C1_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrC1Hi |=> cnt1 == {$past(wrData), $past(latch1[DATA_W-1:0])}); // R5
endmodule

// File: rtl/ifaTimerCore.sv
module ifaTimerCore
  import ifaPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_LSB = 9,
  localparam int REG_MSB = REG_LSB + IDX_W - 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sel,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [REG_MSB:REG_LSB]   busAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     tick,
  input  logic                     shiftEvent,
  output logic [DATA_W-1:0]        rdData,
  output logic                     irq
);
  ifaStrobeT strb;
  regIdxE    rdIdx;

  ifaCtrl ctrl_i (
    .sel   (sel),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .regSel(busAddr),
    .rdIdx (rdIdx),
    .strb  (strb)
  );

  ifaDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdIdx     (rdIdx),
    .wrData    (wrData),
    .tick      (tick),
    .shiftEvent(shiftEvent),
    .rdData    (rdData),
    .irq       (irq)
  );
endmodule

// File: tb/ifaTimerCore_tb.sv
module ifaTimerCore_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [12:9] busAddr = '0;
  logic [7:0] wrData = '0;
  logic       tick = 1'b0, shiftEvent = 1'b0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifaTimerCore dut_i (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .rdEn(rdEn),
    .busAddr(busAddr), .wrData(wrData), .tick(tick),
    .shiftEvent(shiftEvent), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] val);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; busAddr = idx; wrData = val;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] val);
    @(negedge clk);
    sel = 1'b1; rdEn = 1'b1; busAddr = idx;
    #1 val = rdData;
    @(negedge clk);
    sel = 1'b0; rdEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] idx, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(idx, v);
    chk(req, int'(v), int'(exp));
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulseShift();
    @(negedge clk);
    shiftEvent = 1'b1;
    @(negedge clk);
    shiftEvent = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R11 irq", int'(irq), 0);
    rdChk(4'd4, 8'hFF, "R11 c1 lo");
    rdChk(4'd5, 8'hFF, "R11 c1 hi");
    rdChk(4'd6, 8'hFF, "R11 l1 lo");
    rdChk(4'd7, 8'hFF, "R11 l1 hi");
    rdChk(4'd9, 8'hFF, "R11 c2 hi");
    rdChk(4'd8, 8'hFF, "R11 c2 lo");
    rdChk(4'd14, 8'h80, "R11 R3 enables");
    rdChk(4'd13, 8'h00, "R11 flags");
    wr(4'd9, 8'h12);
    rdChk(4'd9, 8'h12, "R8 c2 hi load");
    rdChk(4'd8, 8'h00, "R11 c2 stored low");
  endtask

  task automatic testPlain();
    wr(4'd0, 8'hA5); wr(4'd1, 8'h3C); wr(4'd2, 8'h5A); wr(4'd3, 8'hC3);
    wr(4'd10, 8'h69); wr(4'd11, 8'h00); wr(4'd12, 8'h96); wr(4'd15, 8'h99);
    rdChk(4'd0, 8'hA5, "R1 data B");
    rdChk(4'd1, 8'h3C, "R1 data A");
    rdChk(4'd2, 8'h5A, "R1 dir B");
    rdChk(4'd3, 8'hC3, "R1 dir A");
    rdChk(4'd11, 8'h00, "R1 aux");
    rdChk(4'd12, 8'h96, "R1 periph");
    rdChk(4'd15, 8'h99, "R1 alias");
    rdChk(4'd10, 8'h69, "R1 shift");
  endtask

  task automatic testEnables();
    wr(4'd14, 8'h84);
    rdChk(4'd14, 8'h84, "R2 set bit2");
    wr(4'd14, 8'hC0);
    rdChk(4'd14, 8'hC4, "R2 set keeps others");
    wr(4'd14, 8'h04);
    rdChk(4'd14, 8'hC0, "R2 clear bit2");
    pulseShift();
    rdChk(4'd13, 8'h04, "R12 R3 flag not enabled");
    chk("R4 irq off when disabled", int'(irq), 0);
    wr(4'd14, 8'h84);
    rdChk(4'd13, 8'h84, "R3 summary bit");
    chk("R4 irq on serial", int'(irq), 1);
    rdChk(4'd10, 8'h69, "R12 shift read");
    rdChk(4'd13, 8'h00, "R12 shift read clears");
    chk("R4 irq off after clear", int'(irq), 0);
    pulseShift();
    wr(4'd13, 8'h7B);
    rdChk(4'd13, 8'h84, "R4 zeros leave flag");
    wr(4'd13, 8'h04);
    rdChk(4'd13, 8'h00, "R4 write one clears");
  endtask

  task automatic testFreeRun();
    wr(4'd11, 8'h40);
    wr(4'd6, 8'h03);
    wr(4'd5, 8'h00);
    rdChk(4'd5, 8'h00, "R5 c1 hi loaded");
    rdChk(4'd4, 8'h03, "R5 c1 lo loaded");
    ticks(3);
    rdChk(4'd13, 8'hC0, "R9 first zero flag");
    chk("R4 irq on c1", int'(irq), 1);
    wr(4'd13, 8'h40);
    chk("R4 irq cleared", int'(irq), 0);
    ticks(1);
    rdChk(4'd5, 8'hFF, "R9 passes ffff");
    rdChk(4'd4, 8'hFF, "R9 passes ffff lo");
    ticks(1);
    rdChk(4'd4, 8'h03, "R9 reload after ffff");
    ticks(2);
    rdChk(4'd13, 8'h00, "R9 no early flag");
    ticks(1);
    rdChk(4'd13, 8'hC0, "R9 period latch+2");
    wr(4'd13, 8'h40);
    ticks(5);
    rdChk(4'd13, 8'hC0, "R9 second period");
    rdChk(4'd5, 8'h00, "R7 hi read");
    rdChk(4'd13, 8'hC0, "R7 hi read keeps flag");
    rdChk(4'd4, 8'h00, "R7 lo read");
    rdChk(4'd13, 8'h00, "R7 lo read clears");
    chk("R7 irq low", int'(irq), 0);
  endtask

  task automatic testLatch();
    wr(4'd11, 8'h00);
    wr(4'd6, 8'h05);
    wr(4'd5, 8'h00);
    ticks(5);
    rdChk(4'd13, 8'hC0, "R10 one-shot flag");
    wr(4'd7, 8'h12);
    rdChk(4'd13, 8'h00, "R6 latch hi clears flag");
    rdChk(4'd5, 8'h00, "R6 no reload hi");
    rdChk(4'd7, 8'h12, "R6 latch hi stored");
    wr(4'd4, 8'h07);
    rdChk(4'd6, 8'h07, "R6 index4 sets latch lo");
    rdChk(4'd4, 8'h00, "R6 counter untouched");
  endtask

  task automatic testOneShot();
    logic [7:0] v;
    wr(4'd11, 8'h00);
    wr(4'd6, 8'h02);
    wr(4'd5, 8'h00);
    ticks(2);
    rdChk(4'd13, 8'hC0, "R10 flag at zero");
    wr(4'd13, 8'h40);
    ticks(3);
    rdChk(4'd5, 8'hFF, "R10 wraps hi");
    rdChk(4'd4, 8'hFD, "R10 wraps lo");
    ticks(65533);
    rd(4'd13, v);
    chk("R10 no second flag", int'(v & 8'h40), 0);
    rdChk(4'd4, 8'h00, "R10 counter at zero");
  endtask

  task automatic testSecond();
    wr(4'd13, 8'h7F);
    wr(4'd14, 8'hA0);
    wr(4'd8, 8'h05);
    wr(4'd9, 8'h00);
    rdChk(4'd9, 8'h00, "R8 c2 hi");
    rdChk(4'd8, 8'h05, "R8 c2 lo");
    ticks(5);
    rdChk(4'd13, 8'hA0, "R8 c2 flag");
    chk("R4 c2 no irq", int'(irq), 0);
    rdChk(4'd8, 8'h00, "R8 c2 read");
    rdChk(4'd13, 8'h00, "R8 read clears c2 flag");
    ticks(1);
    rdChk(4'd9, 8'hFF, "R8 c2 wraps");
    ticks(65535);
    rdChk(4'd13, 8'h00, "R8 no re-arm");
    wr(4'd8, 8'h34);
    rdChk(4'd9, 8'h00, "R8 low write no load");
    wr(4'd9, 8'h56);
    rdChk(4'd9, 8'h56, "R8 load hi");
    repeat (20) @(negedge clk);
    rdChk(4'd8, 8'h34, "R13 holds without tick");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPlain();
    testEnables();
    testFreeRun();
    testLatch();
    testOneShot();
    testSecond();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule